// File: doc/BRIEF.md
# Cache Activity Monitor

This block sits beside an instruction cache and keeps four event counters. One counts requests from the processor. One counts reads of the tag RAM. The cache reads tag RAM only when a fetch moves to a new line, so a fetch that stays on the same line is not counted. One counts data RAM accesses, which occur on every request. One counts accesses to the background (main) memory. The cache supplies each event as a single-cycle pulse. The monitor does not interpret the pulses. It counts each one on its own input.

The request counter defines an observation window. The window ends on the request that takes the request count to its all-ones value. At that edge three things happen. The window totals of all four counters move into shadow registers. All live counters start again from zero. An interrupt line is raised. Software uses the frozen totals to estimate memory energy and to choose the next cache associativity and line size. It then acknowledges the interrupt. All registers are reached through a small slave port on the processor data bus. Reads return data in the same cycle as the address. Writes take effect at the clock edge on which the write strobe is high.

Top module: `cache_activity_monitor`

## Requirements
- R1: After reset, every live counter, every shadow register, the enable bit and the interrupt read as zero.
- R2: While enabled, each event pulse adds one to its own counter in the cycle it is sampled. Pulses on other inputs do not affect that counter. Counters wrap modulo 2^CNT_W.
- R3: While the enable bit is low, no live counter changes, no window closes and the interrupt is not raised.
- R4: An enabled request that arrives while the request counter holds all-ones minus one closes the window. Each shadow register then takes its counter's value plus that cycle's pulse, modulo 2^CNT_W, so the request shadow reads all ones. All four live counters read zero after that edge.
- R5: The interrupt rises on the edge that closes a window. It stays high until a control write with bit 2 set. If a window closes in the same cycle as that acknowledge, the interrupt stays high.
- R6: A control write with bit 1 set zeroes all live counters at that edge. It takes priority over same-cycle increments and over a window close. In that case no shadow update and no interrupt occur.
- R7: The register map uses word index `bus_addr`. Index 0 is control: bit 0 is enable (read/write), and bits 1 and 2 are write-only and read as 0. Index 1 is status: bit 0 is the interrupt. Indices 2 to 5 are the live counters, in the order request, tag, data, background. Indices 6 to 9 are the shadow registers in the same order. Every other index reads zero, and writes to it change nothing.
- R8: Shadow registers change only when a window closes. A counter clear does not alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_evt | input | 1 | Processor request pulse |
| tag_evt | input | 1 | Tag RAM read pulse |
| data_evt | input | 1 | Data RAM access pulse |
| bkg_evt | input | 1 | Background memory access pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| irq | output | 1 | Window-closed interrupt |

## Verification
Every counter, shadow, enable and interrupt effect is due at the first rising edge after the pulse or write that causes it. One edge of register state lies between stimulus and result. The bench drives each stimulus cycle on a falling edge and updates its own model just after the rising edge. It then reads back all sixteen register indices at the next falling edge. Read data has no register stage, so each read is compared one time step after its address settles, with no clock edge in between.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int unsigned N_EV     = 4;
  localparam int unsigned EV_REQ   = 0;
  localparam int unsigned IDX_CTRL = 0;
  localparam int unsigned IDX_STAT = 1;
  localparam int unsigned IDX_LIVE = 2;
  localparam int unsigned IDX_SHAD = IDX_LIVE + N_EV;
  localparam int unsigned CTRL_EN  = 0;
  localparam int unsigned CTRL_CLR = 1;
  localparam int unsigned CTRL_ACK = 2;
endpackage

// File: rtl/cam_counter.sv
module cam_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         count_en,
  input  logic         event_i,
  input  logic         clear_i,
  input  logic         close_i,
  output logic [W-1:0] live_o,
  output logic [W-1:0] shadow_o
);
  function automatic logic [W-1:0] bump(input logic [W-1:0] v, input logic inc);
    return v + {{(W-1){1'b0}}, inc};
  endfunction

  logic [W-1:0] stepped;
  assign stepped = bump(live_o, event_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_o   <= '0;
      shadow_o <= '0;
    end else if (clear_i) begin
      live_o <= '0;
    end else if (close_i) begin
      live_o   <= '0;
      shadow_o <= stepped;
    end else if (count_en) begin
      live_o <= stepped;
    end
  end

  p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> live_o == '0);
  p_hold_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !clear_i && !close_i) |=> $stable(live_o));
  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && event_i && !clear_i && !close_i) |=> live_o == $past(live_o) + 1'b1);
  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !close_i |=> $stable(shadow_o));
endmodule

// File: rtl/cam_regs.sv
module cam_regs
  import cam_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned W      = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                close_i,
  input  logic [N_EV*W-1:0]   live_flat,
  input  logic [N_EV*W-1:0]   shadow_flat,
  output logic                enable_o,
  output logic                clear_o,
  output logic                irq_o,
  output logic [DATA_W-1:0]   bus_rdata
);
  logic ctrl_wr;
  logic ack;
  logic unused_wdata_bits;

  assign ctrl_wr           = bus_wr && (bus_addr == ADDR_W'(IDX_CTRL));
  assign clear_o           = ctrl_wr && bus_wdata[CTRL_CLR];
  assign ack               = ctrl_wr && bus_wdata[CTRL_ACK];
  assign unused_wdata_bits = ^bus_wdata[DATA_W-1:CTRL_ACK+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_o <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      if (ctrl_wr) enable_o <= bus_wdata[CTRL_EN];
      if (close_i)  irq_o <= 1'b1;
      else if (ack) irq_o <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(IDX_CTRL)) bus_rdata[CTRL_EN] = enable_o;
    if (bus_addr == ADDR_W'(IDX_STAT)) bus_rdata[0] = irq_o;
    for (int i = 0; i < int'(N_EV); i++) begin
      if (bus_addr == ADDR_W'(IDX_LIVE + i)) bus_rdata = DATA_W'(live_flat[i*W +: W]);
      if (bus_addr == ADDR_W'(IDX_SHAD + i)) bus_rdata = DATA_W'(shadow_flat[i*W +: W]);
    end
  end

  p_irq_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    close_i |=> irq_o);
  p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ack) |=> irq_o);
  p_irq_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !close_i) |=> !irq_o);
  p_irq_only_on_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(close_i));
endmodule

// File: rtl/cache_activity_monitor.sv
module cache_activity_monitor
  import cam_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_evt,
  input  logic              tag_evt,
  input  logic              data_evt,
  input  logic              bkg_evt,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam logic [CNT_W-1:0] LAST_STEP = {{(CNT_W-1){1'b1}}, 1'b0};

  logic [N_EV-1:0]       ev_vec;
  logic [CNT_W-1:0]      live_w   [N_EV];
  logic [CNT_W-1:0]      shadow_w [N_EV];
  logic [N_EV*CNT_W-1:0] live_flat;
  logic [N_EV*CNT_W-1:0] shadow_flat;
  logic                  enable;
  logic                  clear;
  logic                  window_close;

  assign ev_vec       = {bkg_evt, data_evt, tag_evt, req_evt};
  assign window_close = enable && ev_vec[EV_REQ] && !clear && (live_w[EV_REQ] == LAST_STEP);

  for (genvar g = 0; g < int'(N_EV); g++) begin : g_cnt
    cam_counter #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .count_en (enable),
      .event_i  (ev_vec[g]),
      .clear_i  (clear),
      .close_i  (window_close),
      .live_o   (live_w[g]),
      .shadow_o (shadow_w[g])
    );
    assign live_flat[g*CNT_W +: CNT_W]   = live_w[g];
    assign shadow_flat[g*CNT_W +: CNT_W] = shadow_w[g];
  end

  cam_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .W(CNT_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .close_i     (window_close),
    .live_flat   (live_flat),
    .shadow_flat (shadow_flat),
    .enable_o    (enable),
    .clear_o     (clear),
    .irq_o       (irq),
    .bus_rdata   (bus_rdata)
  );

  p_req_never_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    live_w[EV_REQ] != '1);
  p_close_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    window_close |=> (live_w[EV_REQ] == '0) && (shadow_w[EV_REQ] == '1));
endmodule

// File: tb/cache_activity_monitor_tb_top.sv
module cache_activity_monitor_tb_top;
  localparam int TW  = 6;
  localparam int MOD = 1 << TW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_evt = 0, tag_evt = 0, data_evt = 0, bkg_evt = 0;
  logic        bus_wr = 0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  int m_cnt [4];
  int m_sh  [4];
  int m_en  = 0;
  int m_irq = 0;

  always #5 clk = ~clk;

  cache_activity_monitor #(.CNT_W(TW), .ADDR_W(4), .DATA_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_evt(req_evt), .tag_evt(tag_evt),
    .data_evt(data_evt), .bkg_evt(bkg_evt), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic int expect_reg(int idx);
    if (idx == 0) return m_en;
    if (idx == 1) return m_irq;
    if (idx >= 2 && idx <= 5) return m_cnt[idx-2];
    if (idx >= 6 && idx <= 9) return m_sh[idx-6];
    return 0;
  endfunction

  // one stimulus cycle; called at a falling edge
  task automatic step(input logic [3:0] ev, input logic wr = 0,
                      input logic [3:0] addr = 0, input int wdata = 0);
    int clr, ack, close_w;
    {bkg_evt, data_evt, tag_evt, req_evt} = ev;
    bus_wr = wr; bus_addr = addr; bus_wdata = wdata;
    @(posedge clk);
    clr = (wr && addr == 0 && wdata[1]) ? 1 : 0;
    ack = (wr && addr == 0 && wdata[2]) ? 1 : 0;
    close_w = (m_en != 0 && ev[0] && clr == 0 && m_cnt[0] == MOD - 2) ? 1 : 0;
    if (clr != 0) begin
      for (int i = 0; i < 4; i++) m_cnt[i] = 0;
    end else if (close_w != 0) begin
      for (int i = 0; i < 4; i++) begin
        m_sh[i]  = (m_cnt[i] + int'(ev[i])) % MOD;
        m_cnt[i] = 0;
      end
    end else if (m_en != 0) begin
      for (int i = 0; i < 4; i++) m_cnt[i] = (m_cnt[i] + int'(ev[i])) % MOD;
    end
    if (close_w != 0) m_irq = 1;
    else if (ack != 0) m_irq = 0;
    if (wr && addr == 0) m_en = wdata & 1;
    @(negedge clk);
    {bkg_evt, data_evt, tag_evt, req_evt} = 4'b0;
    bus_wr = 0; bus_addr = 0; bus_wdata = 0;
  endtask

  task automatic check_all(input string tag);
    for (int idx = 0; idx < 16; idx++) begin
      bus_addr = idx[3:0];
      #1;
      compared++;
      if (bus_rdata !== 32'(expect_reg(idx))) begin
        mismatched++;
        $display("FAIL %s reg %0d actual=%0d expected=%0d", tag, idx, bus_rdata, expect_reg(idx));
      end
    end
    compared++;
    if (irq !== 1'(m_irq)) begin
      mismatched++;
      $display("FAIL %s irq pin actual=%0b expected=%0d", tag, irq, m_irq);
    end
    bus_addr = 0;
  endtask

  task automatic run_reqs(input int n);
    for (int i = 0; i < n; i++) step(4'b0101);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_sh[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    for (int i = 0; i < 5; i++) step(4'hF);
    check_all("R3 disabled");

    step(4'h0, 1, 0, 1);
    for (int i = 0; i < 40; i++) step(4'(i % 16));
    check_all("R2 pattern sweep");
    for (int i = 0; i < 16; i++) step(4'(15 - i));
    check_all("R2 reverse sweep");

    step(4'hF, 1, 0, 3);
    check_all("R6 clear over increment");

    for (int i = 0; i < MOD - 1; i++)
      step({(i % 5 == 0) ? 1'b1 : 1'b0, 1'b1, (i % 3 == 0) ? 1'b1 : 1'b0, 1'b1});
    check_all("R4 window close");
    check_all("R5 irq raised");

    for (int i = 0; i < 10; i++) step(4'(i));
    check_all("R8 shadow held");
    step(4'h0, 1, 0, 3);
    check_all("R8 shadow after clear");

    step(4'h0, 1, 0, 5);
    check_all("R5 ack");

    run_reqs(MOD - 2);
    step(4'b0001, 1, 0, 5);
    check_all("R5 set beats ack");
    step(4'h0, 1, 0, 5);

    run_reqs(MOD - 2);
    step(4'b1111, 1, 0, 3);
    check_all("R6 clear beats close");

    run_reqs(MOD - 2);
    step(4'h0, 1, 0, 0);
    for (int i = 0; i < 3; i++) step(4'hF);
    check_all("R3 disabled at boundary");

    step(4'h0, 1, 4'd12, 7);
    check_all("R7 write to unused index");
    step(4'h0, 1, 0, 7);
    check_all("R7 control readback");
    step(4'b0011);
    check_all("R7 map after events");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule